// File: doc/BRIEF.md
# Debug Hart Handshake Mailbox

This block is a memory-mapped slave inside a processor debug module. Harts that are in debug mode run a fixed polling loop. In that loop they report their state by writing to a few write-only addresses, and they read one flag byte each to learn whether they should start work or leave debug mode. The block keeps a halted bit and a GO/RESUME flag pair for every hart, plus a latched exception bit.

The debugger drives a small command port. A GO command names one hart and a target. The block first rewrites a single patchable word with a jump instruction to that target (abstract-command area, program buffer or resume entry), and only then raises that hart's GO flag. The hart reads the flag, acknowledges it, and jumps through the patched word. A RESUME command raises a hart's RESUME flag, and several harts may hold that flag at once. Any command that arrives while a GO is still outstanding is turned away with a busy pulse. This keeps the patched word unchanged until the hart has consumed it.

Top module: `dbg_hart_mailbox`

## Requirements
- R1: After reset, all GO and RESUME flags, all halted bits and the exception bit are zero, go_pending_o is low, and the jump word at offset 0x300 holds the JAL to the resume entry (ROM base 0x800 + 4).
- R2: A bus write to offset 0x100 whose data is a hart ID below NUM_HARTS sets that hart's bit in halted_o from the next cycle. Other IDs have no effect.
- R3: A bus write to offset 0x108 with a valid hart ID clears that hart's RESUME flag and its halted bit. Other harts' flags are unchanged.
- R4: A bus write to offset 0x10C sets exception_o. An accepted command with op 2 (clear exception) clears it.
- R5: A bus read of offset 0x400 + h returns hart h's flag byte in rdata[7:0], with GO in bit 0 and RESUME in bit 1, and zero above.
- R6: An accepted GO command (op 0) writes to offset 0x300 the word JAL x0 with offset (target − 0x300) in the standard J-type bit layout. Target code 0 selects the abstract area, 1 the program buffer, and 2 or 3 the resume entry. The word is updated one cycle after the command edge, and the hart's GO flag rises one cycle later.
- R7: At most one hart holds GO at a time. While a GO is pending (from acceptance until acknowledge), every command is rejected: cmd_busy_o pulses, cmd_done_o stays low, and neither the jump word nor any flag changes. A command naming a hart index ≥ NUM_HARTS is also rejected.
- R8: A bus write to offset 0x104 clears the pending GO flag and drops go_pending_o in the next cycle.
- R9: An accepted RESUME command (op 1) sets the named hart's RESUME flag. RESUME flags of several harts can be set at the same time.
- R10: Every bus request gets bus_rvalid_o one cycle later. Reads of unmapped or write-only offsets return zero. Writes to unmapped offsets, to 0x300 and to the flag region change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Hart-side bus request |
| bus_we_i | input | 1 | Write enable |
| bus_addr_i | input | ADDR_W | Byte offset inside the debug module |
| bus_wdata_i | input | 32 | Write data (hart ID for status writes) |
| bus_rdata_o | output | 32 | Read data, one cycle after request |
| bus_rvalid_o | output | 1 | Response valid, one cycle after request |
| cmd_valid_i | input | 1 | Debugger command strobe |
| cmd_op_i | input | 2 | 0 GO, 1 RESUME, 2 clear exception, 3 no-op |
| cmd_hart_i | input | HID_W | Target hart index |
| cmd_target_i | input | 2 | GO target: 0 abstract, 1 program buffer, 2/3 resume |
| cmd_done_o | output | 1 | Command accepted (pulse, next cycle) |
| cmd_busy_o | output | 1 | Command rejected (pulse, next cycle) |
| go_pending_o | output | 1 | A GO is armed or not yet acknowledged |
| halted_o | output | NUM_HARTS | Halted bit per hart |
| exception_o | output | 1 | Latched exception status |

## Verification
A stale or misplaced flag shows up directly: the affected hart's flag byte reads wrong on the very next bus read, and go_pending_o or halted_o differ in the cycle after the triggering write. A jump word that is corrupted or written late is seen on a read of offset 0x300 taken one cycle after the GO command. A flag that is raised too early is caught by reading the flag byte in that same cycle and finding GO already set. A faulty busy interlock shows up as a done pulse or as a changed jump word after a command issued while GO is outstanding.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
  typedef enum logic [1:0] {
    OP_GO      = 2'd0,
    OP_RESUME  = 2'd1,
    OP_CLR_EXC = 2'd2,
    OP_NOP     = 2'd3
  } cmd_op_e;

  localparam int unsigned OFF_HALTED  = 32'h100;
  localparam int unsigned OFF_GO_ACK  = 32'h104;
  localparam int unsigned OFF_RES_ACK = 32'h108;
  localparam int unsigned OFF_EXC     = 32'h10C;
  localparam int unsigned OFF_JUMP    = 32'h300;
  localparam int unsigned OFF_FLAGS   = 32'h400;
  localparam int unsigned OFF_ROM     = 32'h800;
  localparam int unsigned OFF_ROM_RES = OFF_ROM + 32'd4;
  localparam int unsigned NUM_TGT     = 4;
endpackage

// File: rtl/dbg_jal_enc.sv
module dbg_jal_enc #(
  parameter logic [31:0] ORIGIN = 32'h300,
  parameter logic [31:0] TARGET = 32'h804
) (
  output logic [31:0] instr_o
);
  localparam logic [31:0] DELTA = TARGET - ORIGIN;
  // J-type immediate layout, rd = x0, opcode JAL
  assign instr_o = {DELTA[20], DELTA[10:1], DELTA[11], DELTA[19:12], 5'd0, 7'b1101111};
endmodule

// File: rtl/dbg_flag_bank.sv
module dbg_flag_bank #(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_HARTS-1:0] set_go_i,
  input  logic                 clr_go_i,
  input  logic [NUM_HARTS-1:0] set_res_i,
  input  logic [NUM_HARTS-1:0] clr_res_i,
  output logic [NUM_HARTS-1:0] go_o,
  output logic [NUM_HARTS-1:0] res_o
);
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        go_o[h]  <= 1'b0;
        res_o[h] <= 1'b0;
      end else begin
        if (set_go_i[h])      go_o[h] <= 1'b1;
        else if (clr_go_i)    go_o[h] <= 1'b0;
        // debugger request wins over a same-cycle hart ack
        if (set_res_i[h])     res_o[h] <= 1'b1;
        else if (clr_res_i[h]) res_o[h] <= 1'b0;
      end
    end
  end

  a_r7_go_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(go_o))
    else $error("R7: more than one hart holds GO");
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_mbox_pkg::*;
#(
  parameter int          NUM_HARTS   = 4,
  parameter int          HID_W       = 2,
  parameter logic [31:0] ABS_ADDR    = 32'h380,
  parameter logic [31:0] PBUF_ADDR   = 32'h360,
  parameter logic [31:0] JUMP_ADDR   = 32'h300,
  parameter logic [31:0] RESUME_ADDR = 32'h804
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [1:0]           cmd_op_i,
  input  logic [HID_W-1:0]     cmd_hart_i,
  input  logic [1:0]           cmd_target_i,
  input  logic                 go_any_i,
  output logic                 done_o,
  output logic                 busy_o,
  output logic                 pending_o,
  output logic [31:0]          jump_o,
  output logic [NUM_HARTS-1:0] set_go_o,
  output logic [NUM_HARTS-1:0] set_res_o,
  output logic                 clr_exc_o
);
  localparam logic [31:0] TGT_ADDR [NUM_TGT] = '{ABS_ADDR, PBUF_ADDR, RESUME_ADDR, RESUME_ADDR};

  logic [31:0] tgt_instr [NUM_TGT];
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_enc
    dbg_jal_enc #(.ORIGIN(JUMP_ADDR), .TARGET(TGT_ADDR[t])) u_enc (.instr_o(tgt_instr[t]));
  end

  logic             arm_q;
  logic [HID_W-1:0] arm_hart_q;
  logic [31:0]      jump_q;
  logic             done_q, busy_q;
  logic             hart_ok, accept;
  cmd_op_e          op;

  assign op        = cmd_op_e'(cmd_op_i);
  assign hart_ok   = (32'(cmd_hart_i) < NUM_HARTS);
  assign pending_o = arm_q | go_any_i;
  assign accept    = cmd_valid_i & ~pending_o & hart_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q      <= 1'b0;
      arm_hart_q <= '0;
      jump_q     <= tgt_instr[2];
      done_q     <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      done_q <= accept;
      busy_q <= cmd_valid_i & ~accept;
      if (arm_q) arm_q <= 1'b0;
      if (accept && op == OP_GO) begin
        // patch jump word first; flag follows one cycle later
        arm_q      <= 1'b1;
        arm_hart_q <= cmd_hart_i;
        jump_q     <= tgt_instr[cmd_target_i];
      end
    end
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
    assign set_go_o[h]  = arm_q && (32'(arm_hart_q) == h);
    assign set_res_o[h] = accept && (op == OP_RESUME) && (32'(cmd_hart_i) == h);
  end

  assign clr_exc_o = accept && (op == OP_CLR_EXC);
  assign done_o    = done_q;
  assign busy_o    = busy_q;
  assign jump_o    = jump_q;

  a_r7_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && pending_o) |=> (busy_o && !done_o))
    else $error("R7: command accepted while GO pending");

  a_r7_jump_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |=> $stable(jump_o))
    else $error("R7: jump word changed while GO pending");

  a_r6_go_after_patch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(go_any_i) |-> $past(arm_q))
    else $error("R6: GO raised without prior jump patch");
endmodule

// File: rtl/dbg_hart_mailbox.sv
module dbg_hart_mailbox
  import dbg_mbox_pkg::*;
#(
  parameter int          NUM_HARTS = 4,
  parameter int          ADDR_W    = 12,
  parameter int          HID_W     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
  parameter logic [31:0] ABS_ADDR  = 32'h380,
  parameter logic [31:0] PBUF_ADDR = 32'h360
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 bus_rvalid_o,
  input  logic                 cmd_valid_i,
  input  logic [1:0]           cmd_op_i,
  input  logic [HID_W-1:0]     cmd_hart_i,
  input  logic [1:0]           cmd_target_i,
  output logic                 cmd_done_o,
  output logic                 cmd_busy_o,
  output logic                 go_pending_o,
  output logic [NUM_HARTS-1:0] halted_o,
  output logic                 exception_o
);
  localparam int unsigned FLAG_END = OFF_FLAGS + NUM_HARTS;

  logic                 wr, rd;
  logic                 hit_halt, hit_go_ack, hit_res_ack, hit_exc;
  logic                 id_ok;
  logic [NUM_HARTS-1:0] id_onehot;
  logic [NUM_HARTS-1:0] go_q, res_q, set_go, set_res;
  logic [NUM_HARTS-1:0] halted_q;
  logic                 exc_q, clr_exc;
  logic [31:0]          jump_w;
  logic [31:0]          addr32;
  logic                 in_flags;
  logic [31:0]          flag_idx;
  logic [31:0]          rdata_d, rdata_q;
  logic                 rvalid_q;

  assign wr     = bus_req_i & bus_we_i;
  assign rd     = bus_req_i & ~bus_we_i;
  assign addr32 = 32'(bus_addr_i);

  assign hit_halt    = wr && addr32 == OFF_HALTED;
  assign hit_go_ack  = wr && addr32 == OFF_GO_ACK;
  assign hit_res_ack = wr && addr32 == OFF_RES_ACK;
  assign hit_exc     = wr && addr32 == OFF_EXC;
  assign id_ok       = bus_wdata_i < NUM_HARTS;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_id
    assign id_onehot[h] = id_ok && (bus_wdata_i == h);
  end

  dbg_cmd_ctrl #(
    .NUM_HARTS  (NUM_HARTS),
    .HID_W      (HID_W),
    .ABS_ADDR   (ABS_ADDR),
    .PBUF_ADDR  (PBUF_ADDR),
    .JUMP_ADDR  (OFF_JUMP),
    .RESUME_ADDR(OFF_ROM_RES)
  ) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_hart_i  (cmd_hart_i),
    .cmd_target_i(cmd_target_i),
    .go_any_i    (|go_q),
    .done_o      (cmd_done_o),
    .busy_o      (cmd_busy_o),
    .pending_o   (go_pending_o),
    .jump_o      (jump_w),
    .set_go_o    (set_go),
    .set_res_o   (set_res),
    .clr_exc_o   (clr_exc)
  );

  dbg_flag_bank #(.NUM_HARTS(NUM_HARTS)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_go_i (set_go),
    .clr_go_i (hit_go_ack),
    .set_res_i(set_res),
    .clr_res_i(hit_res_ack ? id_onehot : '0),
    .go_o     (go_q),
    .res_o    (res_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= '0;
      exc_q    <= 1'b0;
    end else begin
      if (hit_halt)         halted_q <= halted_q | id_onehot;
      else if (hit_res_ack) halted_q <= halted_q & ~id_onehot;
      if (hit_exc)          exc_q <= 1'b1;
      else if (clr_exc)     exc_q <= 1'b0;
    end
  end

  assign in_flags = (addr32 >= OFF_FLAGS) && (addr32 < FLAG_END);
  assign flag_idx = addr32 - OFF_FLAGS;

  always_comb begin
    rdata_d = '0;
    if (addr32 == OFF_JUMP) begin
      rdata_d = jump_w;
    end else if (in_flags) begin
      for (int h = 0; h < NUM_HARTS; h++) begin
        if (flag_idx == h) rdata_d = {30'd0, res_q[h], go_q[h]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_req_i;
      rdata_q  <= rd ? rdata_d : '0;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign halted_o     = halted_q;
  assign exception_o  = exc_q;

  a_r10_one_cycle_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |=> bus_rvalid_o)
    else $error("R10: missing response");

  a_r2_halt_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_halt && id_ok) |=> ((halted_o & $past(id_onehot)) != '0))
    else $error("R2: halted bit not set");

  a_r3_resume_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_res_ack && id_ok) |=> ((halted_o & $past(id_onehot)) == '0))
    else $error("R3: halted bit not cleared");

  a_r4_exc_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_exc |=> exception_o)
    else $error("R4: exception not latched");

  a_r8_go_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_go_ack && !set_go) |=> !go_pending_o)
    else $error("R8: GO not cleared by ack");
endmodule

// File: tb/dbg_hart_mailbox_tb.sv
`timescale 1ns/1ps
module dbg_hart_mailbox_tb_top;
  localparam int NH = 4;
  localparam int HW = 2;
  localparam int unsigned A_ABS  = 32'h380;
  localparam int unsigned A_PBUF = 32'h360;
  localparam int unsigned A_RES  = 32'h804;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic          cvalid = 1'b0;
  logic [1:0]    cop = '0;
  logic [HW-1:0] chart = '0;
  logic [1:0]    ctgt = '0;
  logic          cdone, cbusy, pend, exc;
  logic [NH-1:0] halted;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dbg_hart_mailbox #(.NUM_HARTS(NH), .ADDR_W(12), .ABS_ADDR(A_ABS), .PBUF_ADDR(A_PBUF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .cmd_valid_i(cvalid), .cmd_op_i(cop), .cmd_hart_i(chart), .cmd_target_i(ctgt),
    .cmd_done_o(cdone), .cmd_busy_o(cbusy), .go_pending_o(pend),
    .halted_o(halted), .exception_o(exc)
  );

  function automatic logic [31:0] jal_word(int unsigned tgt);
    int unsigned d;
    d = tgt - 32'h300;
    return (((d >> 20) & 1) << 31) | (((d >> 1) & 32'h3ff) << 21) |
           (((d >> 11) & 1) << 20) | (((d >> 12) & 32'hff) << 12) | 32'h6f;
  endfunction

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_wr(int unsigned a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a[11:0]; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(int unsigned a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a[11:0];
    @(posedge clk); @(negedge clk);
    check("R10 rvalid", {31'd0, rvalid}, 32'd1);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic cmd(logic [1:0] op, int h, logic [1:0] t, output logic dn, output logic bs);
    cvalid = 1'b1; cop = op; chart = h[HW-1:0]; ctgt = t;
    @(posedge clk); @(negedge clk);
    dn = cdone; bs = cbusy;
    cvalid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0;
    repeat (3) idle();
    rst_n = 1'b1;
    idle();
    check("R1 halted", 32'(halted), 32'd0);
    check("R1 exception", 32'(exc), 32'd0);
    check("R1 pending", 32'(pend), 32'd0);
    for (int h = 0; h < NH; h++) begin
      bus_rd(32'h400 + h, d);
      check("R1 flags", d, 32'd0);
    end
    bus_rd(32'h300, d);
    check("R1 jump word", d, jal_word(A_RES));
  endtask

  task automatic t_halt();
    bus_wr(32'h100, 32'd2);
    check("R2 halted h2", 32'(halted), 32'b0100);
    bus_wr(32'h100, 32'd1);
    check("R2 halted h1", 32'(halted), 32'b0110);
    bus_wr(32'h100, 32'd7);
    check("R2 bad id", 32'(halted), 32'b0110);
  endtask

  task automatic t_go();
    logic [31:0] d; logic dn, bs;
    cmd(2'd0, 1, 2'd0, dn, bs);
    check("R6 done", {30'd0, bs, dn}, 32'b01);
    check("R6 pending", 32'(pend), 32'd1);
    bus_rd(32'h401, d);
    check("R6 flag not yet", d, 32'd0);
    bus_rd(32'h300, d);
    check("R6 jump abstract", d, jal_word(A_ABS));
    bus_rd(32'h401, d);
    check("R5 go bit", d, 32'd1);
    cmd(2'd1, 2, 2'd0, dn, bs);
    check("R7 busy resume", {30'd0, bs, dn}, 32'b10);
    cmd(2'd0, 0, 2'd1, dn, bs);
    check("R7 busy go", {30'd0, bs, dn}, 32'b10);
    bus_rd(32'h300, d);
    check("R7 jump kept", d, jal_word(A_ABS));
    bus_rd(32'h400, d);
    check("R7 h0 no go", d, 32'd0);
    bus_rd(32'h402, d);
    check("R7 h2 no resume", d, 32'd0);
    bus_wr(32'h104, 32'd0);
    check("R8 pending cleared", 32'(pend), 32'd0);
    bus_rd(32'h401, d);
    check("R8 flag cleared", d, 32'd0);
    cmd(2'd0, 0, 2'd1, dn, bs);
    check("R6 done pbuf", {30'd0, bs, dn}, 32'b01);
    bus_rd(32'h300, d);
    check("R6 jump progbuf", d, jal_word(A_PBUF));
    bus_wr(32'h104, 32'd0);
    cmd(2'd0, 3, 2'd2, dn, bs);
    bus_rd(32'h300, d);
    check("R6 jump resume", d, jal_word(A_RES));
    idle();
    bus_rd(32'h403, d);
    check("R5 h3 go", d, 32'd1);
    bus_wr(32'h104, 32'd0);
    cmd(2'd0, 2, 2'd3, dn, bs);
    bus_rd(32'h300, d);
    check("R6 target3 resume", d, jal_word(A_RES));
    bus_wr(32'h104, 32'd0);
    check("R8 pending after ack", 32'(pend), 32'd0);
  endtask

  task automatic t_resume();
    logic [31:0] d; logic dn, bs;
    cmd(2'd1, 1, 2'd0, dn, bs);
    check("R9 done h1", {30'd0, bs, dn}, 32'b01);
    cmd(2'd1, 2, 2'd0, dn, bs);
    check("R9 done h2", {30'd0, bs, dn}, 32'b01);
    bus_rd(32'h401, d);
    check("R9 h1 resume", d, 32'd2);
    bus_rd(32'h402, d);
    check("R9 h2 resume", d, 32'd2);
    bus_wr(32'h108, 32'd2);
    check("R3 halted cleared", 32'(halted), 32'b0010);
    bus_rd(32'h402, d);
    check("R3 h2 resume cleared", d, 32'd0);
    bus_rd(32'h401, d);
    check("R3 h1 resume kept", d, 32'd2);
  endtask

  task automatic t_exc();
    logic dn, bs;
    bus_wr(32'h10C, 32'd0);
    check("R4 set", 32'(exc), 32'd1);
    cmd(2'd2, 0, 2'd0, dn, bs);
    check("R4 clear", 32'(exc), 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(32'h200, 32'd1);
    bus_wr(32'h300, 32'hdeadbeef);
    bus_wr(32'h400, 32'd3);
    bus_wr(32'h401, 32'd0);
    bus_rd(32'h300, d);
    check("R10 jump untouched", d, jal_word(A_RES));
    bus_rd(32'h400, d);
    check("R10 flag h0 untouched", d, 32'd0);
    bus_rd(32'h401, d);
    check("R10 flag h1 untouched", d, 32'd2);
    bus_rd(32'h200, d);
    check("R10 unmapped read", d, 32'd0);
    bus_rd(32'h100, d);
    check("R10 write-only read", d, 32'd0);
    bus_rd(32'h404, d);
    check("R10 beyond flags", d, 32'd0);
    check("R10 halted untouched", 32'(halted), 32'b0010);
    check("R10 pending untouched", 32'(pend), 32'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_halt();
    t_go();
    t_resume();
    t_exc();
    t_unmapped();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule